// File: doc/BRIEF.md
# SCL Timing and Timeout Generator

This block times the clock line of a two-wire serial bus master. It divides the system clock by a programmable amount to make a slower tick. From that tick it builds the low and high phases of SCL, using one of several low-to-high length ratios. When a phase begins, it raises a one-cycle marker. It also watches the sampled bus lines for two faults: a busy bus whose lines have stayed high too long, and an SCL line held low too long.

A transfer sequencer upstream requests clocking with `run`. It follows `low_start_stb` and `high_start_stb` to place data changes and samples. It reacts to the timeout pulses. When go-idle is enabled, a bus-idle timeout also raises `force_idle`, which drives the sequencer back to its idle state.

Byte shifting, acknowledge handling, arbitration and software access are handled elsewhere.

Top module: `scl_timegen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it with `enable` low, every output is 0.
- R2: The tick fires once every `div`+1 system cycles while `enable` is high. Every phase length and timeout window is measured in ticks, so a full low phase lasts Nlow*(`div`+1) cycles.
- R3: `ratio_sel` gives the low:high tick counts: 0 gives 4:4, 1 gives 6:3, 2 gives 11:6, and 3 behaves as 0.
- R4: When `enable` and `run` are both high and clocking has not yet begun, `scl_drive_low` (1 = pull SCL low) rises on the next clock edge. Dropping either input sets `scl_drive_low` to 0 on the next edge.
- R5: The high phase counts ticks only while `scl_in` is sampled high. A device that holds SCL low lengthens the high phase by exactly the held cycles when `div`=0.
- R6: `low_start_stb` is a one-cycle pulse on the cycle `scl_drive_low` becomes 1. `high_start_stb` is a one-cycle pulse on the cycle it becomes 0. The two never pulse together.
- R7: The bus-idle watcher counts ticks while `enable`, `bus_busy`, `scl_in` and `sda_in` are all high. `idle_sel` 1, 2 and 3 expire after 40, 80 and 160 ticks. 0 disables it.
- R8: Any change on `scl_in` or `sda_in` restarts the bus-idle count from zero.
- R9: The clock-low watcher counts ticks while `enable` is high and `scl_in` is low. `low_sel` 1 to 5 expire after 40, 80, 160, 320 and 1024 ticks. 0, 6 and 7 disable it.
- R10: Each expiry gives exactly one single-cycle pulse. A watcher does not fire again until its counting condition has gone false at least once.
- R11: `force_idle` pulses in the same cycle as `idle_tmo_pulse` when `idle_go_en` was high at the expiring edge, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; runs the prescaler and the watchers |
| run | input | 1 | Request to generate SCL phases |
| div | input | DIV_W | Prescaler divisor minus one |
| ratio_sel | input | 2 | Low:high phase ratio code |
| idle_sel | input | 2 | Bus-idle timeout code |
| low_sel | input | 3 | Clock-low timeout code |
| idle_go_en | input | 1 | Turns a bus-idle timeout into a force-idle request |
| scl_in | input | 1 | Sampled SCL level |
| sda_in | input | 1 | Sampled SDA level |
| bus_busy | input | 1 | Bus is marked busy |
| scl_drive_low | output | 1 | 1 requests SCL to be pulled low |
| low_start_stb | output | 1 | Low phase begins |
| high_start_stb | output | 1 | High phase begins |
| idle_tmo_pulse | output | 1 | Bus-idle timeout expired |
| low_tmo_pulse | output | 1 | Clock-low timeout expired |
| force_idle | output | 1 | Request to return to idle |

## Verification
The bench builds the block with its default `DIV_W` of 9. It runs the divisor at 0 for most cases, which makes every system cycle a tick. That puts the longest 1024-tick clock-low window and every ratio within a few thousand cycles. A run with a divisor of 2 shows that phase lengths scale with the divisor.

A bench-side drive of SCL low makes both clock stretching and clock-low faults reachable. The SDA and busy inputs let the bench restart the bus-idle count and rearm it mid-window.

// File: rtl/scl_timegen_pkg.sv
package scl_timegen_pkg;

  localparam int PH_W  = 4;   // holds the longest phase count (11)
  localparam int TMO_W = 11;  // holds the longest timeout (1024)

  typedef enum logic [1:0] {
    RATIO_EVEN = 2'd0,
    RATIO_SKEW = 2'd1,
    RATIO_FAST = 2'd2,
    RATIO_RSVD = 2'd3
  } ratio_e;

  function automatic logic [PH_W-1:0] low_ticks(input logic [1:0] sel);
    case (ratio_e'(sel))
      RATIO_SKEW: return PH_W'(6);
      RATIO_FAST: return PH_W'(11);
      default:    return PH_W'(4);
    endcase
  endfunction

  function automatic logic [PH_W-1:0] high_ticks(input logic [1:0] sel);
    case (ratio_e'(sel))
      RATIO_SKEW: return PH_W'(3);
      RATIO_FAST: return PH_W'(6);
      default:    return PH_W'(4);
    endcase
  endfunction

  // zero means the watcher is disabled
  function automatic logic [TMO_W-1:0] idle_limit(input logic [1:0] sel);
    case (sel)
      2'd1:    return TMO_W'(40);
      2'd2:    return TMO_W'(80);
      2'd3:    return TMO_W'(160);
      default: return '0;
    endcase
  endfunction

  function automatic logic [TMO_W-1:0] low_limit(input logic [2:0] sel);
    case (sel)
      3'd1:    return TMO_W'(40);
      3'd2:    return TMO_W'(80);
      3'd3:    return TMO_W'(160);
      3'd4:    return TMO_W'(320);
      3'd5:    return TMO_W'(1024);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/scl_prescale.sv
module scl_prescale #(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic             wrap;

  // >= keeps a lowered divisor from running on to the counter wrap
  assign wrap = (cnt >= div);
  assign tick = en && wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!en || wrap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq #(
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            tick,
  input  logic            scl_in,
  input  logic [PH_W-1:0] n_low,
  input  logic [PH_W-1:0] n_high,
  output logic            drive_low,
  output logic            low_stb,
  output logic            high_stb
);

  logic            started;
  logic [PH_W-1:0] cnt;
  logic            low_done;
  logic            high_done;

  assign low_done  = (cnt >= n_low  - 1'b1);
  assign high_done = (cnt >= n_high - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      started   <= 1'b0;
      cnt       <= '0;
      drive_low <= 1'b0;
      low_stb   <= 1'b0;
      high_stb  <= 1'b0;
    end else begin
      low_stb  <= 1'b0;
      high_stb <= 1'b0;
      if (!run) begin
        started   <= 1'b0;
        cnt       <= '0;
        drive_low <= 1'b0;
      end else if (!started) begin
        started   <= 1'b1;
        cnt       <= '0;
        drive_low <= 1'b1;
        low_stb   <= 1'b1;
      end else if (drive_low) begin
        if (tick) begin
          if (low_done) begin
            cnt       <= '0;
            drive_low <= 1'b0;
            high_stb  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end else if (tick && scl_in) begin
        // a stretched line holds the high count still
        if (high_done) begin
          cnt       <= '0;
          drive_low <= 1'b1;
          low_stb   <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/scl_tmo_watch.sv
module scl_tmo_watch #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             hit,
  output logic             expire
);

  logic [CNT_W-1:0] cnt;
  logic             fired;
  logic             live;

  assign live = arm && (limit != '0);
  assign hit  = live && !fired && tick && (cnt >= limit - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      fired  <= 1'b0;
      expire <= 1'b0;
    end else begin
      expire <= hit;
      if (!live) begin
        cnt   <= '0;
        fired <= 1'b0;
      end else if (hit) begin
        cnt   <= '0;
        fired <= 1'b1;
      end else if (tick && !fired) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/scl_timegen.sv
module scl_timegen
  import scl_timegen_pkg::*;
#(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  input  logic [1:0]       ratio_sel,
  input  logic [1:0]       idle_sel,
  input  logic [2:0]       low_sel,
  input  logic             idle_go_en,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             bus_busy,
  output logic             scl_drive_low,
  output logic             low_start_stb,
  output logic             high_start_stb,
  output logic             idle_tmo_pulse,
  output logic             low_tmo_pulse,
  output logic             force_idle
);

  localparam int N_WATCH = 2;
  localparam int W_IDLE  = 0;
  localparam int W_LOW   = 1;

  logic                tick;
  logic [N_WATCH-1:0]  arm;
  logic [N_WATCH-1:0]  hit;
  logic [N_WATCH-1:0]  expire;
  logic [TMO_W-1:0]    lim [N_WATCH];
  logic                force_q;

  scl_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .en   (enable),
    .div  (div),
    .tick (tick)
  );

  scl_phase_seq #(.PH_W(PH_W)) u_phase (
    .clk       (clk),
    .rst       (rst),
    .run       (enable && run),
    .tick      (tick),
    .scl_in    (scl_in),
    .n_low     (low_ticks(ratio_sel)),
    .n_high    (high_ticks(ratio_sel)),
    .drive_low (scl_drive_low),
    .low_stb   (low_start_stb),
    .high_stb  (high_start_stb)
  );

  // an edge on either line drops the idle condition, restarting its count
  assign arm[W_IDLE] = enable && bus_busy && scl_in && sda_in;
  assign arm[W_LOW]  = enable && !scl_in;
  assign lim[W_IDLE] = idle_limit(idle_sel);
  assign lim[W_LOW]  = low_limit(low_sel);

  for (genvar g = 0; g < N_WATCH; g++) begin : g_watch
    scl_tmo_watch #(.CNT_W(TMO_W)) u_watch (
      .clk    (clk),
      .rst    (rst),
      .arm    (arm[g]),
      .tick   (tick),
      .limit  (lim[g]),
      .hit    (hit[g]),
      .expire (expire[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      force_q <= 1'b0;
    end else begin
      force_q <= hit[W_IDLE] && idle_go_en;
    end
  end

  assign idle_tmo_pulse = expire[W_IDLE];
  assign low_tmo_pulse  = expire[W_LOW];
  assign force_idle     = force_q;

endmodule

// File: rtl/scl_timegen_chk.sv
module scl_timegen_chk (
  input logic       clk,
  input logic       rst,
  input logic       enable,
  input logic       run,
  input logic [1:0] idle_sel,
  input logic [2:0] low_sel,
  input logic       idle_go_en,
  input logic       scl_in,
  input logic       sda_in,
  input logic       bus_busy,
  input logic       scl_drive_low,
  input logic       low_start_stb,
  input logic       high_start_stb,
  input logic       idle_tmo_pulse,
  input logic       low_tmo_pulse,
  input logic       force_idle
);

  a_r6_strobes_apart: assert property (@(posedge clk) disable iff (rst)
    !(low_start_stb && high_start_stb));

  a_r6_low_stb_pulls: assert property (@(posedge clk) disable iff (rst)
    low_start_stb |-> scl_drive_low);

  a_r6_high_stb_releases: assert property (@(posedge clk) disable iff (rst)
    high_start_stb |-> !scl_drive_low);

  a_r4_stop_releases: assert property (@(posedge clk) disable iff (rst)
    !(enable && run) |=> !scl_drive_low);

  a_r5_stretch_holds: assert property (@(posedge clk) disable iff (rst)
    (enable && run && $past(enable && run) && !scl_drive_low && !scl_in)
      |=> !scl_drive_low);

  a_r10_idle_single: assert property (@(posedge clk) disable iff (rst)
    idle_tmo_pulse |=> !idle_tmo_pulse);

  a_r10_low_single: assert property (@(posedge clk) disable iff (rst)
    low_tmo_pulse |=> !low_tmo_pulse);

  a_r7_idle_off: assert property (@(posedge clk) disable iff (rst)
    ($past(idle_sel) == 2'd0) |-> !idle_tmo_pulse);

  a_r9_low_off: assert property (@(posedge clk) disable iff (rst)
    ($past(low_sel) == 3'd0 || $past(low_sel) >= 3'd6) |-> !low_tmo_pulse);

  a_r8_idle_needs_quiet: assert property (@(posedge clk) disable iff (rst)
    idle_tmo_pulse |-> $past(enable && bus_busy && scl_in && sda_in));

  a_r9_low_needs_low: assert property (@(posedge clk) disable iff (rst)
    low_tmo_pulse |-> $past(enable && !scl_in));

  a_r11_force_paired: assert property (@(posedge clk) disable iff (rst)
    force_idle |-> (idle_tmo_pulse && $past(idle_go_en)));

endmodule

bind scl_timegen scl_timegen_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .enable         (enable),
  .run            (run),
  .idle_sel       (idle_sel),
  .low_sel        (low_sel),
  .idle_go_en     (idle_go_en),
  .scl_in         (scl_in),
  .sda_in         (sda_in),
  .bus_busy       (bus_busy),
  .scl_drive_low  (scl_drive_low),
  .low_start_stb  (low_start_stb),
  .high_start_stb (high_start_stb),
  .idle_tmo_pulse (idle_tmo_pulse),
  .low_tmo_pulse  (low_tmo_pulse),
  .force_idle     (force_idle)
);

// File: tb/test_scl_timegen.sv
module test_scl_timegen;
  timeunit 1ns;
  timeprecision 100ps;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0, run = 1'b0;
  logic [8:0] div = '0;
  logic [1:0] ratio_sel = '0, idle_sel = '0;
  logic [2:0] low_sel = '0;
  logic       idle_go_en = 1'b0, sda_in = 1'b1, bus_busy = 1'b0;
  logic       ext_low = 1'b0;
  logic       scl_in;
  logic       scl_drive_low, low_start_stb, high_start_stb;
  logic       idle_tmo_pulse, low_tmo_pulse, force_idle;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign scl_in = !scl_drive_low && !ext_low;

  scl_timegen i_scl_timegen (
    .clk(clk), .rst(rst), .enable(enable), .run(run), .div(div),
    .ratio_sel(ratio_sel), .idle_sel(idle_sel), .low_sel(low_sel),
    .idle_go_en(idle_go_en), .scl_in(scl_in), .sda_in(sda_in),
    .bus_busy(bus_busy), .scl_drive_low(scl_drive_low),
    .low_start_stb(low_start_stb), .high_start_stb(high_start_stb),
    .idle_tmo_pulse(idle_tmo_pulse), .low_tmo_pulse(low_tmo_pulse),
    .force_idle(force_idle)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  function automatic int ref_low(input int s);
    return (s == 1) ? 6 : (s == 2) ? 11 : 4;
  endfunction
  function automatic int ref_high(input int s);
    return (s == 1) ? 3 : (s == 2) ? 6 : 4;
  endfunction
  function automatic int ref_idle(input int s);
    return (s == 0) ? 0 : 20 << s;
  endfunction
  function automatic int ref_clow(input int s);
    case (s)
      1: return 40;
      2: return 80;
      3: return 160;
      4: return 320;
      5: return 1024;
      default: return 0;
    endcase
  endfunction

  int m_pc, m_ph, m_ic, m_lc;
  bit m_go, m_drv, m_ls, m_hs, m_if, m_lf, m_ip, m_lp, m_fi;

  always @(posedge clk) begin
    bit t, en, rn, sc, hi, hl, ai, al;
    int li, ll;
    en = enable; rn = run; sc = scl_in;
    if (rst) begin
      m_pc = 0; m_ph = 0; m_ic = 0; m_lc = 0;
      m_go = 0; m_drv = 0; m_ls = 0; m_hs = 0;
      m_if = 0; m_lf = 0; m_ip = 0; m_lp = 0; m_fi = 0;
    end else begin
      t = en && (m_pc >= int'(div));
      m_pc = (!en || t) ? 0 : m_pc + 1;
      m_ls = 0; m_hs = 0;
      if (!(en && rn)) begin
        m_go = 0; m_drv = 0; m_ph = 0;
      end else if (!m_go) begin
        m_go = 1; m_drv = 1; m_ph = 0; m_ls = 1;
      end else if (m_drv) begin
        if (t) begin
          if (m_ph + 1 >= ref_low(ratio_sel)) begin m_drv = 0; m_ph = 0; m_hs = 1; end
          else m_ph++;
        end
      end else if (t && sc) begin
        if (m_ph + 1 >= ref_high(ratio_sel)) begin m_drv = 1; m_ph = 0; m_ls = 1; end
        else m_ph++;
      end
      ai = en && bus_busy && sc && sda_in;
      al = en && !sc;
      li = ref_idle(idle_sel);
      ll = ref_clow(low_sel);
      hi = ai && li != 0 && !m_if && t && (m_ic + 1 >= li);
      hl = al && ll != 0 && !m_lf && t && (m_lc + 1 >= ll);
      m_ip = hi; m_lp = hl; m_fi = hi && idle_go_en;
      if (!(ai && li != 0)) begin m_ic = 0; m_if = 0; end
      else if (hi) begin m_ic = 0; m_if = 1; end
      else if (t && !m_if) m_ic++;
      if (!(al && ll != 0)) begin m_lc = 0; m_lf = 0; end
      else if (hl) begin m_lc = 0; m_lf = 1; end
      else if (t && !m_lf) m_lc++;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(scl_drive_low == m_drv, "R4 scl_drive_low vs model", scl_drive_low, m_drv);
      chk(low_start_stb == m_ls && high_start_stb == m_hs, "R6 strobes vs model",
          {low_start_stb, high_start_stb}, {m_ls, m_hs});
      chk(idle_tmo_pulse == m_ip, "R7 idle pulse vs model", idle_tmo_pulse, m_ip);
      chk(low_tmo_pulse == m_lp, "R9 low pulse vs model", low_tmo_pulse, m_lp);
      chk(force_idle == m_fi, "R11 force_idle vs model", force_idle, m_fi);
    end
  end

  // ---------------- directed helpers ----------------
  task automatic wait_low_stb();
    @(negedge clk);
    while (!low_start_stb) @(negedge clk);
  endtask

  task automatic measure(output int lo, output int hi);
    wait_low_stb();
    wait_low_stb();
    lo = 0;
    while (scl_drive_low) begin lo++; @(negedge clk); end
    hi = 0;
    while (!scl_drive_low) begin hi++; @(negedge clk); end
  endtask

  task automatic count_pulse(input bit low_w, input int maxc, output int n);
    n = -1;
    for (int i = 1; i <= maxc; i++) begin
      @(negedge clk);
      if (low_w ? low_tmo_pulse : idle_tmo_pulse) begin n = i; break; end
    end
  endtask

  task automatic idle_case(input int sel, input int exp, input string tag);
    int n;
    bus_busy = 0; @(negedge clk);
    idle_sel = 2'(sel); bus_busy = 1;
    count_pulse(0, exp + 5, n);
    chk(n == exp, tag, n, exp);
  endtask

  task automatic low_case(input int sel, input int exp, input string tag);
    int n;
    ext_low = 0; low_sel = 3'(sel); @(negedge clk);
    ext_low = 1;
    count_pulse(1, (exp > 0) ? exp + 5 : 1100, n);
    chk(n == ((exp > 0) ? exp : -1), tag, n, exp);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lo, hi, n;
    repeat (4) @(negedge clk);
    chk({scl_drive_low, low_start_stb, high_start_stb, idle_tmo_pulse,
         low_tmo_pulse, force_idle} == 6'b0, "R1 outputs in reset", 0, 0);
    rst = 0;
    @(negedge clk);
    chk({scl_drive_low, low_start_stb, high_start_stb, idle_tmo_pulse,
         low_tmo_pulse, force_idle} == 6'b0, "R1 outputs after reset", 0, 0);

    // R4 start and stop
    enable = 1; run = 1;
    @(negedge clk);
    chk(scl_drive_low && low_start_stb, "R4 first pull after run", scl_drive_low, 1);
    // R3 ratios at div 0
    for (int r = 0; r < 4; r++) begin
      ratio_sel = 2'(r);
      measure(lo, hi);
      chk(lo == ref_low(r), $sformatf("R3 ratio %0d low", r), lo, ref_low(r));
      chk(hi == ref_high(r), $sformatf("R3 ratio %0d high", r), hi, ref_high(r));
    end
    // R2 divisor scaling
    div = 9'd2; ratio_sel = 2'd1;
    measure(lo, hi);
    chk(lo == 18, "R2 div2 low length", lo, 18);
    chk(hi == 9, "R2 div2 high length", hi, 9);
    div = '0; ratio_sel = 2'd0;
    // R5 stretching
    wait_low_stb();
    @(negedge clk);
    while (!high_start_stb) @(negedge clk);
    ext_low = 1;
    hi = 1;
    repeat (10) begin @(negedge clk); hi++; end
    ext_low = 0;
    forever begin @(negedge clk); if (scl_drive_low) break; hi++; end
    chk(hi == 14, "R5 stretched high length", hi, 14);
    // R4 stop
    enable = 0;
    @(negedge clk);
    chk(!scl_drive_low, "R4 release on disable", scl_drive_low, 0);
    enable = 1; run = 0;
    @(negedge clk);
    chk(!scl_drive_low, "R4 no pull without run", scl_drive_low, 0);

    // R7 / R11 bus idle
    sda_in = 1; idle_go_en = 1;
    idle_case(1, 40, "R7 idle sel1");
    chk(force_idle, "R11 force with go-idle", force_idle, 1);
    count_pulse(0, 200, n);
    chk(n == -1, "R10 idle no rearm while quiet", n, -1);
    idle_go_en = 0;
    idle_case(1, 40, "R10 idle rearm after drop");
    chk(!force_idle, "R11 no force without go-idle", force_idle, 0);
    idle_case(2, 80, "R7 idle sel2");
    idle_case(3, 160, "R7 idle sel3");
    bus_busy = 0; @(negedge clk);
    idle_sel = 2'd0; bus_busy = 1;
    count_pulse(0, 300, n);
    chk(n == -1, "R7 idle sel0 disabled", n, -1);
    // R8 restart on SDA edge
    bus_busy = 0; @(negedge clk);
    idle_sel = 2'd1; bus_busy = 1;
    repeat (30) @(negedge clk);
    sda_in = 0; @(negedge clk);
    sda_in = 1;
    count_pulse(0, 60, n);
    chk(n == 40, "R8 restart after sda edge", n, 40);
    bus_busy = 0; idle_sel = 2'd0;

    // R9 clock low
    low_case(1, 40, "R9 low sel1");
    count_pulse(1, 100, n);
    chk(n == -1, "R10 low no rearm while held", n, -1);
    low_case(4, 320, "R9 low sel4");
    low_case(5, 1024, "R9 low sel5");
    low_case(0, 0, "R9 low sel0 disabled");
    low_case(6, 0, "R9 low sel6 disabled");
    low_case(7, 0, "R9 low sel7 disabled");
    ext_low = 0;
    repeat (5) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule